// File: doc/BRIEF.md
# Critical-Conduction Switch Gate Sequencer

This block is the digital timing core of a critical-conduction-mode power-factor stage. It receives comparator flags from the analog front end and decides, cycle by cycle of the system clock, when the main power switch is enabled. An on-time lasts until the sensed switch current reaches the peak threshold or an over-current flag trips. A current-sense blanking window at the start of each on-time masks the peak flag. An off-time normally ends when the demagnetization detector first arms and then releases. A restart timer bounds the wait.

The sequencer also runs three special off-time modes. Burst mode is sampled when an on-time ends and forces a long fixed off-time. Low-power mode forces a short fixed off-time after every switching cycle. Fault hold covers over-voltage, feedback short and thermal fault, and keeps the switch off while any of them is present. The feedback-short condition is latched between a trip flag and a separate release flag, which gives hysteresis. After any fault clears, the sequencer restarts from the off state and waits for the full restart timer. Every duration is a parameter counted in clock cycles.

Top module: `crm_gate_seq`

## Requirements
- R1: While reset is asserted, `gate_en` and `cs_blank` are 0. After reset is released, the first turn-on comes OFF_MAX_CYC clock edges later, so exactly OFF_MAX_CYC-1 sampled cycles show the gate low.
- R2: An on-time ends on the first clock edge at which `pk_trip` is high and the on-time has already lasted BLANK_CYC cycles. If `pk_trip` is first seen at on-time cycle j (counting from 0), the gate is high for max(j, BLANK_CYC)+1 cycles.
- R3: `cs_blank` is high for exactly the first BLANK_CYC cycles of every on-time and is never high while the gate is low.
- R4: `oc_trip` ends the on-time on the next clock edge, even inside the blanking window. If it is seen at on-time cycle j, the gate is high for j+1 cycles.
- R5: In a normal off-time, the gate turns on again at the first edge where `demag_low` is high after `demag_arm` was seen on an earlier edge of the same off-time. If `demag_low` arrives without a prior arm, it is ignored.
- R6: If no arm-then-release occurs, a normal off-time ends after OFF_MAX_CYC cycles.
- R7: If `burst_req` is high on the edge that ends an on-time, the following off-time lasts exactly OFF_MAX_CYC cycles and ignores the demagnetization flags. `burst_req` raised only during an off-time does not change that off-time.
- R8: If `lowpwr_req` is high on the edge that ends an on-time, the following off-time lasts exactly LP_OFF_CYC cycles and ignores the demagnetization flags. This takes priority over `burst_req`.
- R9: `fb_ovp` or `therm_flt` forces the gate low from the next clock edge and keeps it low while either flag is present. After both flags drop, the gate stays low for OFF_MAX_CYC-1 sampled cycles and then turns on.
- R10: A one-cycle `fb_short` pulse keeps the gate low indefinitely until `fb_release` is seen. After the release edge, the gate stays low for OFF_MAX_CYC-1 further sampled cycles and then turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pk_trip | input | 1 | Switch current has reached the peak (multiplier) threshold |
| oc_trip | input | 1 | Switch current is above the absolute current limit |
| demag_arm | input | 1 | Demagnetization sense is above its arm level |
| demag_low | input | 1 | Demagnetization sense is below its disarm level |
| burst_req | input | 1 | Control voltage is below the burst threshold |
| fb_ovp | input | 1 | Feedback is above the over-voltage limit |
| fb_short | input | 1 | Feedback is below the short trip level |
| fb_release | input | 1 | Feedback is above the short release level |
| lowpwr_req | input | 1 | Low-power shutdown requested |
| therm_flt | input | 1 | Thermal fault |
| gate_en | output | 1 | Enable for the main switch gate driver |
| cs_blank | output | 1 | Leading-edge blanking of the current-sense path |

## Verification
On every cycle, the assertions check the following:
- A peak trip past blanking or an over-current trip ends the on-time on the next edge.
- Any fault flag leaves the gate off on the next edge.
- Blanking only ever accompanies an enabled gate and is present on the first cycle of each on-time.
- The feedback-short latch holds the gate off until its release flag appears.

The exact lengths of on-times and off-times can only be shown by the bench's sweeps. These include blanking-window edges, arm-then-release timing, the restart timer, the burst and low-power durations, mode priority, and restart after a fault.

// File: rtl/crm_pkg.sv
package crm_pkg;

   typedef enum logic [2:0] {
      ST_WAIT  = 3'd0,   // restart wait after reset or fault
      ST_ON    = 3'd1,   // switch conducting
      ST_DEMAG = 3'd2,   // normal off-time, watching demagnetization
      ST_BURST = 3'd3,   // long fixed off-time
      ST_LOWP  = 3'd4    // short fixed off-time
   } crm_state_e;

endpackage

// File: rtl/crm_tick_cnt.sv
module crm_tick_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("crm_tick_cnt: W must be at least 1");
   end

   // saturating up-counter, restarted at every state change
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (clr)        q <= '0;
      else if (q != '1)    q <= q + 1'b1;
   end

endmodule

// File: rtl/crm_fault_gate.sv
module crm_fault_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic ovp_i,
   input  logic therm_i,
   input  logic short_trip_i,
   input  logic short_clr_i,
   output logic halt_o,
   output logic short_o
);

   logic short_q;

   // hysteretic latch: set by the low trip, cleared only by the higher release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            short_q <= 1'b0;
      else if (short_trip_i) short_q <= 1'b1;
      else if (short_clr_i)  short_q <= 1'b0;
   end

   assign short_o = short_q;
   assign halt_o  = ovp_i | therm_i | short_trip_i | short_q;

endmodule

// File: rtl/crm_seq_fsm.sv
module crm_seq_fsm
   import crm_pkg::*;
#(
   parameter int unsigned BLANK_CYC   = 14,
   parameter int unsigned OFF_MAX_CYC = 34000,
   parameter int unsigned LP_OFF_CYC  = 4200,
   parameter int unsigned W           = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_i,
   input  logic pk_i,
   input  logic oc_i,
   input  logic zarm_i,
   input  logic zlow_i,
   input  logic burst_i,
   input  logic lowp_i,
   output logic gate_o,
   output logic blank_o
);

   localparam logic [W-1:0] OFF_LAST = W'(OFF_MAX_CYC - 1);
   localparam logic [W-1:0] LP_LAST  = W'(LP_OFF_CYC - 1);

   crm_state_e   st, nxt;
   logic [W-1:0] cnt;
   logic         cnt_clr;
   logic         armed;
   logic         past_blank;

   crm_tick_cnt #(.W(W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .q     (cnt)
   );

   // blanking variant: none at all, or a counted leading-edge window
   if (BLANK_CYC == 0) begin : g_noblank
      assign past_blank = 1'b1;
      assign blank_o    = 1'b0;
   end else begin : g_blank
      localparam logic [W-1:0] BLANK_W = W'(BLANK_CYC);
      assign past_blank = (cnt >= BLANK_W);
      assign blank_o    = (st == ST_ON) && !past_blank;
   end

   always_comb begin
      nxt     = st;
      cnt_clr = 1'b0;
      if (halt_i) begin
         nxt     = ST_WAIT;
         cnt_clr = 1'b1;
      end else begin
         unique case (st)
            ST_WAIT:  if (cnt == OFF_LAST) nxt = ST_ON;
            ST_ON: begin
               if (oc_i || (pk_i && past_blank)) begin
                  if (lowp_i)       nxt = ST_LOWP;
                  else if (burst_i) nxt = ST_BURST;
                  else              nxt = ST_DEMAG;
               end
            end
            ST_DEMAG: if ((armed && zlow_i) || cnt == OFF_LAST) nxt = ST_ON;
            ST_BURST: if (cnt == OFF_LAST) nxt = ST_ON;
            ST_LOWP:  if (cnt == LP_LAST)  nxt = ST_ON;
            default:  nxt = ST_WAIT;
         endcase
         if (nxt != st) cnt_clr = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_WAIT;
         armed <= 1'b0;
      end else begin
         st    <= nxt;
         armed <= (st == ST_DEMAG && nxt == ST_DEMAG) ? (armed | zarm_i) : 1'b0;
      end
   end

   assign gate_o = (st == ST_ON);

   // R3: blanking never outside an on-time
   p_blank_in_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      blank_o |-> gate_o);

   // R8: a low-power off-time never runs past its fixed length
   p_lowp_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOWP) |-> (cnt <= LP_LAST));

   // R6: no normal off-time outlives the restart timer
   p_off_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEMAG && cnt == OFF_LAST && !halt_i) |=> gate_o);

endmodule

// File: rtl/crm_gate_seq.sv
module crm_gate_seq
   import crm_pkg::*;
#(
   parameter int unsigned BLANK_CYC   = 14,
   parameter int unsigned OFF_MAX_CYC = 34000,
   parameter int unsigned LP_OFF_CYC  = 4200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pk_trip,
   input  logic oc_trip,
   input  logic demag_arm,
   input  logic demag_low,
   input  logic burst_req,
   input  logic fb_ovp,
   input  logic fb_short,
   input  logic fb_release,
   input  logic lowpwr_req,
   input  logic therm_flt,
   output logic gate_en,
   output logic cs_blank
);

   localparam int unsigned MAX_A = (OFF_MAX_CYC > LP_OFF_CYC) ? OFF_MAX_CYC : LP_OFF_CYC;
   localparam int unsigned MAX_L = (MAX_A > BLANK_CYC) ? MAX_A : BLANK_CYC;
   localparam int unsigned CW    = $clog2(MAX_L + 1);

   if (OFF_MAX_CYC < 2 || LP_OFF_CYC < 1) begin : g_bad_off
      $error("crm_gate_seq: off-time limits too small");
   end
   if (BLANK_CYC >= OFF_MAX_CYC) begin : g_bad_blank
      $error("crm_gate_seq: blanking must be shorter than the restart timer");
   end

   logic halt;
   logic short_held;

   crm_fault_gate u_fault (
      .clk          (clk),
      .rst_n        (rst_n),
      .ovp_i        (fb_ovp),
      .therm_i      (therm_flt),
      .short_trip_i (fb_short),
      .short_clr_i  (fb_release),
      .halt_o       (halt),
      .short_o      (short_held)
   );

   crm_seq_fsm #(
      .BLANK_CYC   (BLANK_CYC),
      .OFF_MAX_CYC (OFF_MAX_CYC),
      .LP_OFF_CYC  (LP_OFF_CYC),
      .W           (CW)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .halt_i  (halt),
      .pk_i    (pk_trip),
      .oc_i    (oc_trip),
      .zarm_i  (demag_arm),
      .zlow_i  (demag_low),
      .burst_i (burst_req),
      .lowp_i  (lowpwr_req),
      .gate_o  (gate_en),
      .blank_o (cs_blank)
   );

   // R4: over-current ends conduction on the next edge
   p_oc_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && oc_trip) |=> !gate_en);

   // R2: peak trip outside blanking ends conduction
   p_pk_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && pk_trip && !cs_blank) |=> !gate_en);

   // R9: any fault flag leaves the gate off on the next edge
   p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_ovp || therm_flt || fb_short) |=> !gate_en);

   // R10: a held short stays off until the release flag
   p_short_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (short_held && !fb_release) |=> !gate_en);

   // R3: every on-time opens with blanking when a window is configured
   if (BLANK_CYC > 0) begin : g_blank_chk
      p_blank_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate_en) |-> cs_blank);
   end

endmodule

// File: tb/test_crm_gate_seq.sv
module test_crm_gate_seq;

   localparam int B  = 3;
   localparam int OM = 20;
   localparam int LP = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pk = 0, oc = 0, zarm = 0, zlow = 0, burst = 0;
   logic ovp = 0, fshort = 0, frel = 0, lowp = 0, therm = 0;
   logic gate, blank;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   crm_gate_seq #(.BLANK_CYC(B), .OFF_MAX_CYC(OM), .LP_OFF_CYC(LP)) i_crm_gate_seq (
      .clk(clk), .rst_n(rst_n), .pk_trip(pk), .oc_trip(oc),
      .demag_arm(zarm), .demag_low(zlow), .burst_req(burst),
      .fb_ovp(ovp), .fb_short(fshort), .fb_release(frel),
      .lowpwr_req(lowp), .therm_flt(therm),
      .gate_en(gate), .cs_blank(blank));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go_on();
      for (int g = 0; g < 200; g++) begin
         if (gate) break;
         step();
      end
      chk("go_on gate", int'(gate), 1);
   endtask

   // count high and blanked cycles of one on-time; trip driven after sample trip_at
   task automatic on_phase(input int trip_at, input bit use_oc, output int hi, output int bl);
      hi = 0; bl = 0;
      for (int j = 0; j < 60; j++) begin
         if (!gate) break;
         hi++;
         if (blank) bl++;
         if (j == trip_at) begin
            if (use_oc) oc = 1; else pk = 1;
         end
         step();
      end
      pk = 0; oc = 0;
   endtask

   // count low cycles of one off-time with a demag stimulus schedule
   task automatic off_phase(input int arm_at, input int arm_len, input int low_at, output int lo);
      lo = 0;
      for (int i = 0; i < 200; i++) begin
         if (gate) break;
         lo++;
         zarm = (i >= arm_at) && (i < arm_at + arm_len);
         zlow = (i >= low_at);
         step();
      end
      zarm = 0; zlow = 0;
   endtask

   // count low samples after a release step until the gate rises
   task automatic restart_len(output int lo);
      lo = 0;
      for (int i = 0; i < 200; i++) begin
         step();
         if (gate) break;
         lo++;
      end
   endtask

   initial begin
      int hi, bl, lo, bad;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 gate in reset", int'(gate), 0);
      chk("R1 blank in reset", int'(blank), 0);
      rst_n = 1'b1;
      restart_len(lo);
      chk("R1 first turn-on", lo, OM - 1);

      // R2/R3: peak trip swept across and beyond the blanking window
      for (int j = 0; j < 8; j++) begin
         go_on();
         on_phase(j, 0, hi, bl);
         chk("R2 on length vs peak trip", hi, ((j > B) ? j : B) + 1);
         chk("R3 blank length", bl, B);
         off_phase(0, 1, 1, lo);
         chk("R5 quick demag restart", lo, 2);
      end

      // R4: over-current ends on the next edge, even inside blanking
      for (int j = 0; j < 6; j++) begin
         go_on();
         on_phase(j, 1, hi, bl);
         chk("R4 on length vs oc trip", hi, j + 1);
         chk("R3 blank under oc", bl, (j + 1 < B) ? j + 1 : B);
         off_phase(0, 1, 1, lo);
      end

      // R5: arm held for a cycles, then release
      for (int a = 1; a < 6; a++) begin
         go_on();
         on_phase(B, 0, hi, bl);
         off_phase(0, a, a, lo);
         chk("R5 arm then release", lo, a + 1);
      end

      // R5/R6: release without arm is ignored; arm without release times out
      go_on();
      on_phase(B, 0, hi, bl);
      off_phase(999, 0, 0, lo);
      chk("R6 release without arm", lo, OM);
      go_on();
      on_phase(B, 0, hi, bl);
      off_phase(0, 100, 999, lo);
      chk("R6 arm without release", lo, OM);

      // R7: burst sampled at end of on-time
      go_on();
      burst = 1;
      on_phase(B, 0, hi, bl);
      burst = 0;
      off_phase(0, 1, 1, lo);
      chk("R7 burst off length", lo, OM);
      go_on();
      on_phase(B, 0, hi, bl);
      burst = 1;
      off_phase(0, 1, 1, lo);
      burst = 0;
      chk("R7 burst during off ignored", lo, 2);

      // R8: low-power fixed off-time and priority over burst
      go_on();
      lowp = 1;
      on_phase(B, 0, hi, bl);
      off_phase(0, 1, 1, lo);
      chk("R8 low-power off length", lo, LP);
      burst = 1;
      go_on();
      on_phase(B, 0, hi, bl);
      off_phase(999, 0, 999, lo);
      chk("R8 low-power over burst", lo, LP);
      lowp = 0; burst = 0;
      go_on();
      on_phase(B, 0, hi, bl);
      off_phase(0, 1, 1, lo);

      // R9: over-voltage during on-time
      go_on();
      step();
      ovp = 1;
      step();
      chk("R9 ovp cuts gate", int'(gate), 0);
      bad = 0;
      for (int k = 0; k < 30; k++) begin
         step();
         if (gate || blank) bad++;
      end
      chk("R9 held off under ovp", bad, 0);
      ovp = 0;
      restart_len(lo);
      chk("R9 restart after ovp", lo, OM - 1);

      // R9: thermal fault during off-time, demag pulses ignored
      on_phase(B, 0, hi, bl);
      therm = 1;
      bad = 0;
      for (int k = 0; k < 30; k++) begin
         zarm = (k == 2); zlow = (k > 3);
         step();
         if (gate) bad++;
      end
      zarm = 0; zlow = 0;
      chk("R9 held off under thermal", bad, 0);
      therm = 0;
      restart_len(lo);
      chk("R9 restart after thermal", lo, OM - 1);

      // R10: short latched by a single pulse until release
      step();
      fshort = 1;
      step();
      fshort = 0;
      chk("R10 short cuts gate", int'(gate), 0);
      bad = 0;
      for (int k = 0; k < 3 * OM; k++) begin
         step();
         if (gate) bad++;
      end
      chk("R10 held off until release", bad, 0);
      frel = 1;
      step();
      frel = 0;
      restart_len(lo);
      chk("R10 restart after release", lo, OM - 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule